// File: doc/BRIEF.md
# Serial Command-List Scanner

This block keeps a 64-byte command and response store that a host reaches through a 32-bit, big-endian word port with per-byte lane enables. The last byte of the store is a control byte. A host write to the final word that enables its lowest lane starts the engine. The control value then picks one of three behaviours: a delayed interrupt, a challenge exchange, or a walk over the store.

The walk reads the store one byte at a time and tracks a channel number. Zero bytes step the channel forward. Padding bytes are skipped. Terminator bytes end the walk. Any other byte opens a self-describing frame, and the engine emits a descriptor for it to a downstream device port, then waits for that port to accept it. Channels 0 to 3 go to controller devices. Channel 4 goes to a cartridge device, whose command code is decoded into a device kind.

A second kind of walk, the read-phase walk, starts on a host request. It collects results. It uses a wider set of padding codes and dispatches only to the controller channels. In challenge mode, fifteen store bytes travel as thirty nibbles to an external response unit, and the answer is written back into the same place.

Top module: `cmd_list_scanner`

## Requirements
- R1: The store holds 64 bytes, and all of them read as zero after reset. A host read returns the word on `host_rdata` one cycle after the request. A request at a byte offset of 64 or more writes nothing, and a read there returns zero.
- R2: A host write changes only the bytes whose lanes are enabled. `host_be[3]`/`host_wdata[31:24]` go to offset+0, and so on down to `host_be[0]`/`host_wdata[7:0]`, which go to offset+3.
- R3: Only a host write to offset 0x3C with `host_be[0]` set, made while idle, starts the engine. It acts on the control byte at 0x3F. A control value of 0 or 1 starts a write-phase walk at byte 0 with the channel at 0. The same write with `host_be[0]` clear starts nothing.
- R4: When the control value is 0x08, the control byte is cleared, no walk runs, and `irq` pulses exactly 0x900 (the DELAY parameter) cycles after the clock edge that took the trigger write.
- R5: When the control value is 0x02, bytes 48..62 are presented on `chal_nibbles`, with byte 48's high nibble in bits [119:116]. On `chal_ack`, `chal_resp` is stored back into bytes 48..62 in the same order, bytes 46, 47 and 63 become zero, and `irq` pulses.
- R6: Any other control value above 1 gives a one-cycle `err` pulse, no walk and no `irq`.
- R7: During a walk, a 0x00 byte advances the channel by one, and the walk ends if the channel then exceeds 6. A 0xFF byte is skipped. In the write phase, a byte with bit 7 or bit 6 set ends the walk.
- R8: `rd_scan_req` starts a read-phase walk (`disp_rd`=1). In this walk 0xB4, 0x56 and 0xB8 are also skipped and 0xFE ends the walk. Frames on channels 4 and above advance the walk without dispatch or error.
- R9: Any other byte starts a frame at offset p. Its value is the transmit length, and bits [5:0] of byte p+1 give the receive length. The walk resumes at p+tx+rx+2 and the channel increments. The walk ends once the position reaches 64.
- R10: A dispatched frame raises `disp_valid` with channel, offset, lengths and kind. All of these hold steady until a cycle with `disp_ready` high. Controller channels 0..3 use kind 0.
- R11: In the write phase, a channel-4 frame takes its code from byte p+2 and maps it to a kind: 0x00 to 1, 0x04 to 2, 0x05 to 3, 0x06 to 4, 0x07 to 5, 0x08 to 6. An unknown code, or any frame on channel 5 or above, gives an `err` pulse and no dispatch.
- R12: When any walk ends, `irq` pulses for one cycle, in the cycle that `busy` falls.
- R13: A completed challenge sets a flag. While the flag is set, `rd_scan_req` is ignored. Every trigger write clears the flag.
- R14: `busy` is high from the trigger until the engine returns to idle. Host writes made while busy change no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Byte offset of the word |
| host_wdata | input | 32 | Write word, big-endian |
| host_be | input | 4 | Byte lane enables |
| host_rdata | output | 32 | Registered read word |
| rd_scan_req | input | 1 | Request a read-phase walk |
| busy | output | 1 | Engine active |
| irq | output | 1 | Completion pulse |
| err | output | 1 | Error pulse |
| disp_valid | output | 1 | Descriptor valid |
| disp_ready | input | 1 | Downstream accepts descriptor |
| disp_chan | output | 3 | Channel number |
| disp_off | output | 6 | Frame offset in the store |
| disp_tx | output | 6 | Transmit length |
| disp_rx | output | 6 | Receive length |
| disp_kind | output | 3 | Device kind |
| disp_rd | output | 1 | Descriptor comes from a read-phase walk |
| chal_req | output | 1 | Challenge data presented |
| chal_nibbles | output | 120 | Challenge nibbles |
| chal_ack | input | 1 | Response is valid |
| chal_resp | input | 120 | Response nibbles |

## Verification
Two things can meet in one cycle: a host write arriving while a descriptor waits for acceptance, and the acceptance itself. The bench holds `disp_ready` low and writes a word during the wait. It then raises `disp_ready` in the same cycle as a second write to a different word. After the walk ends, it reads both words back and expects zero from each. The descriptor must stay unchanged across the wait, and the next descriptor must carry the next frame's fields.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [1:0] {
    CL_CHSKIP,
    CL_PAD,
    CL_END,
    CL_FRAME
  } byte_cls_t;

  typedef enum logic [2:0] {
    K_CTRL      = 3'd0,
    K_CART_STAT = 3'd1,
    K_CART_RD   = 3'd2,
    K_CART_WR   = 3'd3,
    K_CLK_STAT  = 3'd4,
    K_CLK_RD    = 3'd5,
    K_CLK_WR    = 3'd6,
    K_NONE      = 3'd7
  } dev_kind_t;

  localparam logic [7:0] CTL_DELAY = 8'h08;
  localparam logic [7:0] CTL_CHAL  = 8'h02;

  // Cartridge command code to device kind
  function automatic dev_kind_t cart_kind(input logic [7:0] code);
    case (code)
      8'h00:   return K_CART_STAT;
      8'h04:   return K_CART_RD;
      8'h05:   return K_CART_WR;
      8'h06:   return K_CLK_STAT;
      8'h07:   return K_CLK_RD;
      8'h08:   return K_CLK_WR;
      default: return K_NONE;
    endcase
  endfunction

endpackage

// File: rtl/scan_ram.sv
module scan_ram #(
  parameter int DEPTH   = 64,
  parameter int CHAL_LO = 48,
  parameter int CHAL_N  = 15,
  localparam int WIDX_W = $clog2(DEPTH / 4)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [WIDX_W-1:0]       wr_word,
  input  logic [31:0]             wr_data,
  input  logic [3:0]              wr_be,
  input  logic                    clr_ctl,
  input  logic                    chal_wr,
  input  logic [CHAL_N*8-1:0]     chal_data,
  output logic [DEPTH-1:0][7:0]   mem_q
);

  for (genvar b = 0; b < DEPTH; b++) begin : g_byte
    localparam int LANE = 3 - (b % 4);
    logic       host_hit;
    logic       eng_wr;
    logic [7:0] eng_d;
    logic [7:0] q;

    assign host_hit = wr_en && (wr_word == WIDX_W'(b / 4)) && wr_be[LANE];

    if (b >= CHAL_LO && b < CHAL_LO + CHAL_N) begin : g_resp
      assign eng_wr = chal_wr;
      assign eng_d  = chal_data[(CHAL_LO + CHAL_N - 1 - b)*8 +: 8];
    end else if (b == DEPTH - 1) begin : g_ctl
      assign eng_wr = chal_wr | clr_ctl;
      assign eng_d  = 8'h00;
    end else if (b == CHAL_LO - 2 || b == CHAL_LO - 1) begin : g_zero
      assign eng_wr = chal_wr;
      assign eng_d  = 8'h00;
    end else begin : g_plain
      assign eng_wr = 1'b0;
      assign eng_d  = 8'h00;
    end

    always_ff @(posedge clk) begin
      if (rst)           q <= 8'h00;
      else if (host_hit) q <= wr_data[LANE*8 +: 8];
      else if (eng_wr)   q <= eng_d;
    end

    assign mem_q[b] = q;
  end

endmodule

// File: rtl/scan_classify.sv
module scan_classify
  import scan_pkg::*;
(
  input  logic [7:0] cur,
  input  logic       rd_phase,
  output byte_cls_t  cls
);

  always_comb begin
    if (cur == 8'h00)
      cls = CL_CHSKIP;
    else if (cur == 8'hFF)
      cls = CL_PAD;
    else if (rd_phase && (cur == 8'hB4 || cur == 8'h56 || cur == 8'hB8))
      cls = CL_PAD;
    else if (cur[7:6] != 2'b00)
      cls = CL_END;
    else
      cls = CL_FRAME;
  end

endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
  import scan_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int DELAY   = 2304,
  parameter int NCTRL   = 4,
  parameter int CART_CH = 4,
  parameter int MAX_CH  = 6,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 2,
  localparam int CW     = AW + 1,
  localparam int DW     = $clog2(DELAY),
  localparam int CHW    = $clog2(MAX_CH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trig,
  input  logic            rd_req,
  input  logic [7:0]      ctl_byte,
  input  logic [7:0]      cur_byte,
  input  logic [5:0]      rx_bits,
  input  logic [7:0]      code_byte,
  input  byte_cls_t       cls,
  input  logic            disp_ready,
  input  logic            chal_ack,
  output logic [PW-1:0]   ptr,
  output logic            rd_phase,
  output logic            busy,
  output logic            irq,
  output logic            err,
  output logic            disp_valid,
  output logic [CHW-1:0]  disp_chan,
  output logic [AW-1:0]   disp_off,
  output logic [5:0]      disp_tx,
  output logic [5:0]      disp_rx,
  output logic [2:0]      disp_kind,
  output logic            clr_ctl,
  output logic            chal_req,
  output logic            chal_wr
);

  typedef enum logic [2:0] {S_IDLE, S_DECIDE, S_WALK, S_DISP, S_DELAY, S_CHAL} st_t;

  st_t            state;
  logic [CW-1:0]  chan;
  logic [DW-1:0]  dcnt;
  logic           chal_flag;
  dev_kind_t      d_kind;
  dev_kind_t      ck;

  assign busy       = (state != S_IDLE);
  assign disp_valid = (state == S_DISP);
  assign chal_req   = (state == S_CHAL);
  assign chal_wr    = chal_req && chal_ack;
  assign clr_ctl    = (state == S_DECIDE) && (ctl_byte == CTL_DELAY);
  assign disp_kind  = d_kind;
  assign ck         = cart_kind(code_byte);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      ptr       <= '0;
      chan      <= '0;
      dcnt      <= '0;
      rd_phase  <= 1'b0;
      chal_flag <= 1'b0;
      irq       <= 1'b0;
      err       <= 1'b0;
      disp_chan <= '0;
      disp_off  <= '0;
      disp_tx   <= '0;
      disp_rx   <= '0;
      d_kind    <= K_CTRL;
    end else begin
      irq <= 1'b0;
      err <= 1'b0;
      case (state)
        S_IDLE: begin
          if (trig) begin
            state     <= S_DECIDE;
            chal_flag <= 1'b0;
            rd_phase  <= 1'b0;
          end else if (rd_req && !chal_flag) begin
            state    <= S_WALK;
            rd_phase <= 1'b1;
            ptr      <= '0;
            chan     <= '0;
          end
        end
        S_DECIDE: begin
          if (ctl_byte == CTL_DELAY) begin
            state <= S_DELAY;
            dcnt  <= DW'(DELAY - 2);
          end else if (ctl_byte == CTL_CHAL) begin
            state <= S_CHAL;
          end else if (ctl_byte > 8'h01) begin
            err   <= 1'b1;
            state <= S_IDLE;
          end else begin
            state <= S_WALK;
            ptr   <= '0;
            chan  <= '0;
          end
        end
        S_WALK: begin
          if (ptr >= PW'(DEPTH)) begin
            irq   <= 1'b1;
            state <= S_IDLE;
          end else begin
            case (cls)
              CL_CHSKIP: begin
                chan <= chan + 1'b1;
                ptr  <= ptr + 1'b1;
                if (chan >= CW'(MAX_CH)) begin
                  irq   <= 1'b1;
                  state <= S_IDLE;
                end
              end
              CL_PAD: ptr <= ptr + 1'b1;
              CL_END: begin
                irq   <= 1'b1;
                state <= S_IDLE;
              end
              default: begin
                ptr       <= ptr + PW'(cur_byte[5:0]) + PW'(rx_bits) + PW'(2);
                chan      <= chan + 1'b1;
                disp_chan <= CHW'(chan);
                disp_off  <= ptr[AW-1:0];
                disp_tx   <= cur_byte[5:0];
                disp_rx   <= rx_bits;
                if (chan < CW'(NCTRL)) begin
                  d_kind <= K_CTRL;
                  state  <= S_DISP;
                end else if (!rd_phase) begin
                  if (chan == CW'(CART_CH) && ck != K_NONE) begin
                    d_kind <= ck;
                    state  <= S_DISP;
                  end else begin
                    err <= 1'b1;
                  end
                end
              end
            endcase
          end
        end
        S_DISP: if (disp_ready) state <= S_WALK;
        S_DELAY: begin
          if (dcnt == '0) begin
            irq   <= 1'b1;
            state <= S_IDLE;
          end else begin
            dcnt <= dcnt - 1'b1;
          end
        end
        S_CHAL: begin
          if (chal_ack) begin
            chal_flag <= 1'b1;
            irq       <= 1'b1;
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10: descriptor held while waiting for acceptance
  assert_disp_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && !disp_ready) |=> (disp_valid && $stable({disp_chan, disp_off, disp_tx, disp_rx, disp_kind})));

  // R11: kind agrees with channel and phase
  assert_disp_route_R11: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> ((disp_kind == 3'd0) ? (disp_chan < CHW'(NCTRL))
                                        : (disp_chan == CHW'(CART_CH) && !rd_phase)));

  // R12: completion pulse only when the engine has returned to idle
  assert_irq_idle_R12: assert property (@(posedge clk) disable iff (rst)
    irq |-> !busy);

  // R13: read request blocked by challenge flag
  assert_chal_block_R13: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !trig && rd_req && chal_flag) |=> !busy);

  // R4: control byte cleared during the delay wait
  assert_delay_ctl_R4: assert property (@(posedge clk) disable iff (rst)
    (state == S_DELAY) |-> (ctl_byte == 8'h00));

endmodule

// File: rtl/cmd_list_scanner.sv
module cmd_list_scanner
  import scan_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int ADDR_W  = 8,
  parameter int DELAY   = 2304,
  parameter int CHAL_LO = 48,
  parameter int CHAL_N  = 15,
  localparam int AW     = $clog2(DEPTH),
  localparam int WIDX_W = $clog2(DEPTH / 4),
  localparam int PW     = AW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 host_req,
  input  logic                 host_we,
  input  logic [ADDR_W-1:0]    host_addr,
  input  logic [31:0]          host_wdata,
  input  logic [3:0]           host_be,
  output logic [31:0]          host_rdata,
  input  logic                 rd_scan_req,
  output logic                 busy,
  output logic                 irq,
  output logic                 err,
  output logic                 disp_valid,
  input  logic                 disp_ready,
  output logic [2:0]           disp_chan,
  output logic [5:0]           disp_off,
  output logic [5:0]           disp_tx,
  output logic [5:0]           disp_rx,
  output logic [2:0]           disp_kind,
  output logic                 disp_rd,
  output logic                 chal_req,
  output logic [CHAL_N*8-1:0]  chal_nibbles,
  input  logic                 chal_ack,
  input  logic [CHAL_N*8-1:0]  chal_resp
);

  logic [DEPTH-1:0][7:0] mem_q;
  logic                  in_range;
  logic [WIDX_W-1:0]     waddr;
  logic                  wr_en;
  logic                  trig;
  logic                  clr_ctl;
  logic                  chal_wr;
  logic [PW-1:0]         ptr;
  logic [AW-1:0]         p0;
  logic [7:0]            cur_byte;
  logic [7:0]            rx_byte;
  logic [7:0]            code_byte;
  logic [31:0]           rd_word;
  byte_cls_t             cls;

  assign in_range = host_addr < ADDR_W'(DEPTH);
  assign waddr    = host_addr[AW-1:2];
  assign wr_en    = host_req && host_we && in_range && !busy;
  assign trig     = wr_en && (waddr == WIDX_W'(DEPTH / 4 - 1)) && host_be[0];

  scan_ram #(.DEPTH(DEPTH), .CHAL_LO(CHAL_LO), .CHAL_N(CHAL_N)) i_ram (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(waddr), .wr_data(host_wdata),
    .wr_be(host_be), .clr_ctl(clr_ctl), .chal_wr(chal_wr), .chal_data(chal_resp),
    .mem_q(mem_q)
  );

  always_comb begin
    for (int l = 0; l < 4; l++)
      rd_word[(3-l)*8 +: 8] = mem_q[{waddr, 2'(l)}];
  end

  always_ff @(posedge clk) begin
    if (rst)
      host_rdata <= '0;
    else if (host_req && !host_we)
      host_rdata <= in_range ? rd_word : 32'h0;
  end

  for (genvar i = 0; i < CHAL_N; i++) begin : g_chal
    assign chal_nibbles[(CHAL_N-1-i)*8 +: 8] = mem_q[CHAL_LO + i];
  end

  assign p0        = ptr[AW-1:0];
  assign cur_byte  = mem_q[p0];
  assign rx_byte   = mem_q[p0 + AW'(1)];
  assign code_byte = mem_q[p0 + AW'(2)];

  scan_classify i_cls (.cur(cur_byte), .rd_phase(disp_rd), .cls(cls));

  scan_fsm #(.DEPTH(DEPTH), .DELAY(DELAY)) i_fsm (
    .clk(clk), .rst(rst), .trig(trig), .rd_req(rd_scan_req),
    .ctl_byte(mem_q[DEPTH-1]), .cur_byte(cur_byte), .rx_bits(rx_byte[5:0]),
    .code_byte(code_byte), .cls(cls), .disp_ready(disp_ready), .chal_ack(chal_ack),
    .ptr(ptr), .rd_phase(disp_rd), .busy(busy), .irq(irq), .err(err),
    .disp_valid(disp_valid), .disp_chan(disp_chan), .disp_off(disp_off),
    .disp_tx(disp_tx), .disp_rx(disp_rx), .disp_kind(disp_kind),
    .clr_ctl(clr_ctl), .chal_req(chal_req), .chal_wr(chal_wr)
  );

  // R1: out-of-range read yields zero
  assert_reject_read_R1: assert property (@(posedge clk) disable iff (rst)
    (host_req && !host_we && !in_range) |=> (host_rdata == 32'h0));

  // R14: host write while a descriptor waits leaves the store untouched
  assert_busy_write_R14: assert property (@(posedge clk) disable iff (rst)
    (host_req && host_we && disp_valid) |=> $stable(mem_q));

endmodule

// File: tb/test_cmd_list_scanner.sv
`timescale 1ns/1ps
module test_cmd_list_scanner;

  localparam int DLY = 2304;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         host_req = 1'b0, host_we = 1'b0;
  logic [7:0]   host_addr = '0;
  logic [31:0]  host_wdata = '0;
  logic [3:0]   host_be = '0;
  logic [31:0]  host_rdata;
  logic         rd_scan_req = 1'b0;
  logic         busy, irq, err, disp_valid, disp_rd, chal_req;
  logic         disp_ready = 1'b0, chal_ack = 1'b0;
  logic [2:0]   disp_chan, disp_kind;
  logic [5:0]   disp_off, disp_tx, disp_rx;
  logic [119:0] chal_nibbles;
  logic [119:0] chal_resp = '0;

  int checks = 0, fails = 0;
  int irq_cnt = 0, err_cnt = 0, dv_cnt = 0;
  logic prev_dv = 1'b0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  cmd_list_scanner i_cmd_list_scanner (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_be(host_be), .host_rdata(host_rdata),
    .rd_scan_req(rd_scan_req), .busy(busy), .irq(irq), .err(err),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_chan(disp_chan),
    .disp_off(disp_off), .disp_tx(disp_tx), .disp_rx(disp_rx), .disp_kind(disp_kind),
    .disp_rd(disp_rd), .chal_req(chal_req), .chal_nibbles(chal_nibbles),
    .chal_ack(chal_ack), .chal_resp(chal_resp)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (irq) irq_cnt++;
      if (err) err_cnt++;
      if (disp_valid && !prev_dv) dv_cnt++;
    end
    prev_dv = disp_valid;
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d; host_be = be;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    host_req = 1'b0;
    d = host_rdata;
  endtask

  task automatic wait_dv();
    int n = 0;
    while (!disp_valid && n < 3000) begin @(negedge clk); n++; end
  endtask

  task automatic accept();
    disp_ready = 1'b1;
    @(negedge clk);
    disp_ready = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 6000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  // {addr, be, wdata, expected readback}
  localparam logic [75:0] VEC [6] = '{
    {8'h00, 4'hF, 32'h11223344, 32'h11223344},
    {8'h00, 4'h5, 32'hAABBCCDD, 32'h11BB33DD},
    {8'h10, 4'h8, 32'hFF000000, 32'hFF000000},
    {8'h3C, 4'hE, 32'h01020300, 32'h01020300},
    {8'h40, 4'hF, 32'h12345678, 32'h00000000},
    {8'h04, 4'h0, 32'hFFFFFFFF, 32'h00000000}
  };

  initial begin
    logic [31:0] rd;
    int i0, e0, d0, k, hit;

    do_reset();
    // Reset state (R1)
    chk("R1 busy after reset", 128'(busy), 128'(0));
    chk("R12 irq after reset", 128'(irq), 128'(0));
    chk("R10 disp_valid after reset", 128'(disp_valid), 128'(0));
    hread(8'h00, rd);
    chk("R1 store zero after reset", 128'(rd), 128'(0));

    // Lane merge table (R1, R2, R3 no trigger without lane 0)
    for (int v = 0; v < 6; v++) begin
      hwrite(VEC[v][75:68], VEC[v][63:32], VEC[v][67:64]);
      chk("R3 no start without trigger lane", 128'(busy), 128'(0));
      hread(VEC[v][75:68], rd);
      chk($sformatf("R2 R1 vector %0d", v), 128'(rd), 128'(VEC[v][31:0]));
    end

    // Scenario A: write-phase walk
    do_reset();
    hwrite(8'h00, 32'hFF010400, 4'hF);
    hwrite(8'h08, 32'h0003C200, 4'hF);
    hwrite(8'h10, 32'h00020304, 4'hF);
    hwrite(8'h18, 32'h01010000, 4'hF);
    hwrite(8'h1C, 32'hFE000000, 4'hF);
    i0 = irq_cnt; e0 = err_cnt; d0 = dv_cnt;
    hwrite(8'h3C, 32'h00000001, 4'h1);
    chk("R14 busy after trigger", 128'(busy), 128'(1));
    wait_dv();
    chk("R10 R9 desc0", 128'({disp_chan, disp_off, disp_tx, disp_rx, disp_kind, disp_rd}),
        128'({3'd0, 6'd1, 6'd1, 6'd4, 3'd0, 1'b0}));
    hwrite(8'h20, 32'hDEADBEEF, 4'hF);
    chk("R10 desc held", 128'({disp_valid, disp_chan, disp_off}), 128'({1'b1, 3'd0, 6'd1}));
    host_req = 1'b1; host_we = 1'b1; host_addr = 8'h24; host_wdata = 32'hCAFEF00D; host_be = 4'hF;
    disp_ready = 1'b1;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0; disp_ready = 1'b0;
    wait_dv();
    chk("R9 R7 desc1", 128'({disp_chan, disp_off, disp_tx, disp_rx, disp_kind}),
        128'({3'd2, 6'd9, 6'd3, 6'd2, 3'd0}));
    accept();
    wait_dv();
    chk("R11 desc2 cart read", 128'({disp_chan, disp_off, disp_tx, disp_rx, disp_kind}),
        128'({3'd4, 6'd17, 6'd2, 6'd3, 3'd2}));
    accept();
    wait_idle();
    chk("R11 channel 5 error", 128'(err_cnt - e0), 128'(1));
    chk("R12 irq at walk end", 128'(irq_cnt - i0), 128'(1));
    chk("R7 end byte stops walk", 128'(dv_cnt - d0), 128'(3));
    hread(8'h20, rd);
    chk("R14 write during wait ignored", 128'(rd), 128'(0));
    hread(8'h24, rd);
    chk("R14 write at accept ignored", 128'(rd), 128'(0));

    // Scenario B: read-phase walk
    do_reset();
    hwrite(8'h00, 32'hB456B800, 4'hF);
    hwrite(8'h04, 32'h01020000, 4'hF);
    hwrite(8'h08, 32'h00FF0000, 4'hF);
    hwrite(8'h0C, 32'h01010000, 4'hF);
    hwrite(8'h10, 32'hFE000000, 4'hF);
    i0 = irq_cnt; e0 = err_cnt; d0 = dv_cnt;
    @(negedge clk); rd_scan_req = 1'b1; @(negedge clk); rd_scan_req = 1'b0;
    wait_dv();
    chk("R8 read-phase desc", 128'({disp_chan, disp_off, disp_tx, disp_rx, disp_kind, disp_rd}),
        128'({3'd1, 6'd4, 6'd1, 6'd2, 3'd0, 1'b1}));
    accept();
    wait_idle();
    chk("R8 channel 4 silent", 128'({dv_cnt - d0, err_cnt - e0}), 128'({32'd1, 32'd0}));
    chk("R12 irq read-phase end", 128'(irq_cnt - i0), 128'(1));

    // Scenario C: unknown cartridge code and channel limit
    do_reset();
    hwrite(8'h04, 32'h01003300, 4'hF);
    i0 = irq_cnt; e0 = err_cnt; d0 = dv_cnt;
    hwrite(8'h3C, 32'h00000000, 4'h1);
    wait_idle();
    chk("R11 unknown code error", 128'(err_cnt - e0), 128'(1));
    chk("R7 channel limit stop", 128'({dv_cnt - d0, irq_cnt - i0}), 128'({32'd0, 32'd1}));

    // Scenario D: illegal control value
    do_reset();
    i0 = irq_cnt; e0 = err_cnt;
    hwrite(8'h3C, 32'h00000005, 4'h1);
    wait_idle();
    chk("R6 error pulse", 128'(err_cnt - e0), 128'(1));
    chk("R6 no irq", 128'(irq_cnt - i0), 128'(0));

    // Scenario E: delayed interrupt
    do_reset();
    hwrite(8'h3C, 32'h00000008, 4'h1);
    hit = 0;
    for (k = 1; k <= DLY + 10 && hit == 0; k++) begin
      @(negedge clk);
      if (irq) hit = k;
    end
    chk("R4 irq delay", 128'(hit), 128'(DLY));
    hread(8'h3C, rd);
    chk("R4 control cleared", 128'(rd), 128'(0));

    // Scenario F: challenge exchange
    do_reset();
    hwrite(8'h2C, 32'hAABBCCDD, 4'hF);
    hwrite(8'h30, 32'h10325476, 4'hF);
    hwrite(8'h34, 32'h98BADCFE, 4'hF);
    hwrite(8'h38, 32'h01234567, 4'hF);
    i0 = irq_cnt;
    hwrite(8'h3C, 32'h89ABCD02, 4'hF);
    k = 0;
    while (!chal_req && k < 20) begin @(negedge clk); k++; end
    chk("R5 nibbles out", 128'(chal_nibbles), 128'(120'h1032547698BADCFE0123456789ABCD));
    chal_resp = ~chal_nibbles; chal_ack = 1'b1;
    @(negedge clk);
    chal_ack = 1'b0;
    wait_idle();
    chk("R5 irq", 128'(irq_cnt - i0), 128'(1));
    hread(8'h2C, rd); chk("R5 bytes 46 47 zero", 128'(rd), 128'(32'hAABB0000));
    hread(8'h30, rd); chk("R5 resp 48", 128'(rd), 128'(32'hEFCDAB89));
    hread(8'h34, rd); chk("R5 resp 52", 128'(rd), 128'(32'h67452301));
    hread(8'h38, rd); chk("R5 resp 56", 128'(rd), 128'(32'hFEDCBA98));
    hread(8'h3C, rd); chk("R5 resp 60 and byte 63", 128'(rd), 128'(32'h76543200));
    @(negedge clk); rd_scan_req = 1'b1; @(negedge clk); rd_scan_req = 1'b0;
    chk("R13 read walk suppressed", 128'(busy), 128'(0));
    hwrite(8'h3C, 32'h00000001, 4'h1);
    wait_idle();
    @(negedge clk); rd_scan_req = 1'b1; @(negedge clk); rd_scan_req = 1'b0;
    chk("R13 flag cleared by trigger", 128'(busy), 128'(1));
    wait_idle();

    finish_run();
  end

endmodule